// File: doc/BRIEF.md
# Ping-Pong Capture Buffer Coordinator

This block steers continuous image capture into two memory regions, buffer A and buffer B. The host can drain one region while the sensor-side writer fills the other. At every frame start the block decides whether the frame may be written and, if so, which region receives it. It publishes the chosen region as an index and as a base address. It also keeps one "full" flag per region.

A region's flag is raised when the writer reports that a frame has been fully written into it. The flag is lowered by a readout-done pulse that belongs to that region. A frame that arrives while both regions hold unread data is dropped. Each dropped frame is tallied in a saturating counter.

The block acts only while ping-pong capture mode is selected. In the other capture mode it grants no frames and counts no drops. All inputs are synchronous to one clock; any clock-domain crossing is handled outside.

Top module: `pp_coordinator`

## Requirements
- R1: During and after a synchronous reset, `cap_en` is 0, `full_flags` is 2'b00, `skip_cnt` is 0, `frame_avail` is 0, `cap_buf` is 0 and `cap_base` equals the buffer A base.
- R2: When both flags are clear at a granted frame start, the region other than the one written last is chosen. Buffer A has index 0 and buffer B has index 1. Right after reset, the first frame goes to buffer A.
- R3: When exactly one flag is set at a frame start, the region whose flag is clear is chosen, even if it is the region written last.
- R4: A granted frame start sets `cap_en` to 1 on the next clock edge. On the same edge, `cap_buf` is set to the chosen index and `cap_base` to that region's base address (BASE_A for index 0, BASE_B for index 1).
- R5: `frame_done` while `cap_en` is 1 has four effects on the next edge: the flag of `cap_buf` is set, `cap_en` falls, and `frame_avail` pulses high for exactly one cycle with `avail_buf` equal to that region's index.
- R6: `rd_done_a` clears `full_flags[0]` and `rd_done_b` clears `full_flags[1]` on the next edge. If a region's flag is being set and cleared in the same cycle, the set wins.
- R7: A frame start in ping-pong mode, with `cap_en` low and both flags set, grants nothing. It increments `skip_cnt`, which holds at 255 once it reaches 255.
- R8: While `pp_mode_en` is 0, a frame start grants nothing and does not change `skip_cnt`. Readout-done pulses still clear flags.
- R9: A frame start while `cap_en` is 1 is ignored. A `frame_done` while `cap_en` is 0 changes no flag and raises no `frame_avail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pp_mode_en | input | 1 | 1 selects ping-pong capture mode |
| frame_start | input | 1 | One-cycle pulse at the start of a sensor frame |
| frame_done | input | 1 | One-cycle pulse when the writer has finished the frame |
| rd_done_a | input | 1 | Host finished reading buffer A |
| rd_done_b | input | 1 | Host finished reading buffer B |
| cap_en | output | 1 | Writer may store the current frame |
| cap_buf | output | 1 | Target region index (0 = A, 1 = B) |
| cap_base | output | ADDR_W | Base address of the target region |
| full_flags | output | 2 | Per-region full flags, bit 0 = A, bit 1 = B |
| frame_avail | output | 1 | One-cycle pulse when a region becomes full |
| avail_buf | output | 1 | Index of the region that just became full |
| skip_cnt | output | SKIP_W | Saturating count of dropped frames |

## Verification
Every result is registered once, so each is due exactly one clock edge after the input pulse that causes it:
- the grant, index and base address follow a frame start;
- the flag set and the `frame_avail` pulse follow a frame done;
- a flag clear follows a readout-done pulse;
- a counter step follows a refused frame start.

The bench drives each pulse on a falling edge and holds it for one full cycle. It reads the outputs on the next falling edge, which is half a cycle after the edge that captured them. The one-cycle width of `frame_avail` is confirmed by a second read one cycle later.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int NUM_BUF = 2;
  typedef enum logic {BUF_A = 1'b0, BUF_B = 1'b1} pp_buf_e;
endpackage

// File: rtl/pp_slot_picker.sv
module pp_slot_picker
  import pp_pkg::*;
(
  input  logic [NUM_BUF-1:0] full,
  input  pp_buf_e            last_buf,
  output logic               found,
  output pp_buf_e            pick
);
  pp_buf_e pref;

  always_comb begin
    pref  = pp_buf_e'(~last_buf);
    found = 1'b0;
    pick  = pref;
    if (!full[pref]) begin
      found = 1'b1;
      pick  = pref;
    end else if (!full[last_buf]) begin
      found = 1'b1;
      pick  = last_buf;
    end
  end
endmodule

// File: rtl/pp_full_flags.sv
module pp_full_flags
  import pp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_BUF-1:0] set_vec,
  input  logic [NUM_BUF-1:0] clr_vec,
  output logic [NUM_BUF-1:0] full
);
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             full[i] <= 1'b0;
      else if (set_vec[i]) full[i] <= 1'b1;
      else if (clr_vec[i]) full[i] <= 1'b0;
    end

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[i] && !set_vec[i]) |=> !full[i]) else $error("clear lost"); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> full[i]) else $error("set lost"); // R6
  end
endmodule

// File: rtl/pp_skip_counter.sv
module pp_skip_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
  end

  AST_SKIP_SATURATES: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == TOP)) else $error("skip wrapped"); // R7
  AST_SKIP_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1)) else $error("skip step"); // R7
endmodule

// File: rtl/pp_coordinator.sv
module pp_coordinator
  import pp_pkg::*;
#(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_A = '0,
  parameter logic [ADDR_W-1:0] BASE_B = 32'h0080_0000,
  parameter int                SKIP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pp_mode_en,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic              rd_done_a,
  input  logic              rd_done_b,
  output logic              cap_en,
  output logic              cap_buf,
  output logic [ADDR_W-1:0] cap_base,
  output logic [1:0]        full_flags,
  output logic              frame_avail,
  output logic              avail_buf,
  output logic [SKIP_W-1:0] skip_cnt
);
  pp_buf_e            last_buf;
  pp_buf_e            pick;
  logic               found;
  logic               start_ok, grant, skip_ev, finish;
  logic [NUM_BUF-1:0] set_vec, clr_vec;

  assign start_ok = pp_mode_en && frame_start && !cap_en;
  assign grant    = start_ok && found;
  assign skip_ev  = start_ok && !found;
  assign finish   = cap_en && frame_done;
  assign set_vec  = finish ? (cap_buf ? 2'b10 : 2'b01) : 2'b00;
  assign clr_vec  = {rd_done_b, rd_done_a};

  pp_slot_picker u_pick (
    .full     (full_flags),
    .last_buf (last_buf),
    .found    (found),
    .pick     (pick)
  );

  pp_full_flags u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .full    (full_flags)
  );

  pp_skip_counter #(.W(SKIP_W)) u_skip (
    .clk (clk),
    .rst (rst),
    .inc (skip_ev),
    .cnt (skip_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en      <= 1'b0;
      cap_buf     <= BUF_A;
      cap_base    <= BASE_A;
      last_buf    <= BUF_B;
      frame_avail <= 1'b0;
      avail_buf   <= BUF_A;
    end else begin
      frame_avail <= finish;
      if (finish) begin
        cap_en    <= 1'b0;
        avail_buf <= cap_buf;
        last_buf  <= pp_buf_e'(cap_buf);
      end else if (grant) begin
        cap_en   <= 1'b1;
        cap_buf  <= pick;
        cap_base <= (pick == BUF_B) ? BASE_B : BASE_A;
      end
    end
  end

  AST_GRANT_FREE_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(cap_en) |-> !full_flags[cap_buf]) else $error("granted full buffer"); // R3
  AST_DONE_SETS_A: assert property (@(posedge clk) disable iff (rst)
    (finish && !cap_buf) |=> (full_flags[0] && frame_avail && !avail_buf && !cap_en))
    else $error("done A"); // R5
  AST_DONE_SETS_B: assert property (@(posedge clk) disable iff (rst)
    (finish && cap_buf) |=> (full_flags[1] && frame_avail && avail_buf && !cap_en))
    else $error("done B"); // R5
  AST_AVAIL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_avail |=> !frame_avail) else $error("avail wide"); // R5
  AST_MODE_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!pp_mode_en && !cap_en) |=> !cap_en) else $error("grant in other mode"); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !frame_done) |=> (cap_en && $stable(cap_buf) && $stable(cap_base)))
    else $error("busy changed"); // R9
  AST_BASE_MATCH: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> (cap_base == (cap_buf ? BASE_B : BASE_A))) else $error("base mismatch"); // R4
endmodule

// File: tb/sim_pp_coordinator.sv
module sim_pp_coordinator;
  localparam int          AW = 32;
  localparam logic [31:0] BA = 32'h0000_0000;
  localparam logic [31:0] BB = 32'h0080_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic pp_mode_en = 1'b1, frame_start = 1'b0, frame_done = 1'b0;
  logic rd_done_a = 1'b0, rd_done_b = 1'b0;
  logic cap_en, cap_buf, frame_avail, avail_buf;
  logic [AW-1:0] cap_base;
  logic [1:0] full_flags;
  logic [7:0] skip_cnt;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  pp_coordinator #(.ADDR_W(AW), .BASE_A(BA), .BASE_B(BB), .SKIP_W(8)) u0 (
    .clk, .rst, .pp_mode_en, .frame_start, .frame_done, .rd_done_a, .rd_done_b,
    .cap_en, .cap_buf, .cap_base, .full_flags, .frame_avail, .avail_buf, .skip_cnt
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task tick; @(negedge clk); endtask

  task do_reset;
    tick; rst = 1'b1; pp_mode_en = 1'b1; tick; tick; rst = 1'b0;
  endtask

  task p_start; frame_start = 1'b1; tick; frame_start = 1'b0; endtask
  task p_done;  frame_done  = 1'b1; tick; frame_done  = 1'b0; endtask
  task p_rda;   rd_done_a   = 1'b1; tick; rd_done_a   = 1'b0; endtask
  task p_rdb;   rd_done_b   = 1'b1; tick; rd_done_b   = 1'b0; endtask

  task automatic do_frame(input string tag, input logic b, input logic [1:0] full_after);
    p_start;
    chk({tag, " R4 cap_en"}, cap_en, 1);
    chk({tag, " R4 cap_buf"}, cap_buf, b);
    chk({tag, " R4 cap_base"}, cap_base, b ? BB : BA);
    p_done;
    chk({tag, " R5 frame_avail"}, frame_avail, 1);
    chk({tag, " R5 avail_buf"}, avail_buf, b);
    chk({tag, " R5 full"}, full_flags, full_after);
    chk({tag, " R5 cap_en low"}, cap_en, 0);
    tick;
    chk({tag, " R5 avail one cycle"}, frame_avail, 0);
  endtask

  task t_reset;
    tick; rst = 1'b1; tick; tick;
    chk("R1 cap_en in reset", cap_en, 0);
    rst = 1'b0; tick;
    chk("R1 cap_en", cap_en, 0);
    chk("R1 full", full_flags, 0);
    chk("R1 skip", skip_cnt, 0);
    chk("R1 avail", frame_avail, 0);
    chk("R1 cap_buf", cap_buf, 0);
    chk("R1 cap_base", cap_base, BA);
  endtask

  task t_alternate;
    do_reset;
    do_frame("R2 first", 1'b0, 2'b01);
    do_frame("R2 second", 1'b1, 2'b11);
    p_rda; p_rdb;
    chk("R6 both cleared", full_flags, 2'b00);
    do_frame("R2 third", 1'b0, 2'b01);
  endtask

  task t_pref_full;
    do_reset;
    do_frame("R3 fillA", 1'b0, 2'b01);
    do_frame("R3 fillB", 1'b1, 2'b11);
    p_rdb;
    chk("R6 rd_done_b clears bit1", full_flags, 2'b01);
    do_frame("R3 reuse B", 1'b1, 2'b11);
  endtask

  task t_skip;
    do_reset;
    do_frame("R7 fillA", 1'b0, 2'b01);
    do_frame("R7 fillB", 1'b1, 2'b11);
    p_start;
    chk("R7 no grant", cap_en, 0);
    chk("R7 skip 1", skip_cnt, 1);
    p_start;
    chk("R7 skip 2", skip_cnt, 2);
    chk("R7 flags kept", full_flags, 2'b11);
  endtask

  task t_saturate;
    do_reset;
    do_frame("R7s fillA", 1'b0, 2'b01);
    do_frame("R7s fillB", 1'b1, 2'b11);
    for (int i = 0; i < 254; i++) begin p_start; tick; end
    chk("R7 skip 254", skip_cnt, 254);
    p_start; tick;
    chk("R7 skip 255", skip_cnt, 255);
    p_start; tick;
    chk("R7 saturated", skip_cnt, 255);
    p_rda;
    do_frame("R7s after clear", 1'b0, 2'b11);
    chk("R7 skip held", skip_cnt, 255);
  endtask

  task t_mode_off;
    do_reset;
    pp_mode_en = 1'b0;
    p_start;
    chk("R8 no grant", cap_en, 0);
    pp_mode_en = 1'b1;
    do_frame("R8 fillA", 1'b0, 2'b01);
    do_frame("R8 fillB", 1'b1, 2'b11);
    pp_mode_en = 1'b0;
    p_start;
    chk("R8 no skip count", skip_cnt, 0);
    chk("R8 no grant full", cap_en, 0);
    p_rda;
    chk("R8 clear works", full_flags, 2'b10);
    p_start;
    chk("R8 free but off", cap_en, 0);
    pp_mode_en = 1'b1;
  endtask

  task t_busy;
    do_reset;
    p_start;
    chk("R9 grant", cap_en, 1);
    p_start;
    chk("R9 still A", cap_buf, 0);
    chk("R9 still busy", cap_en, 1);
    chk("R9 no skip", skip_cnt, 0);
    p_done; tick;
    chk("R9 one flag", full_flags, 2'b01);
    p_done;
    chk("R9 idle done no avail", frame_avail, 0);
    chk("R9 idle done flags", full_flags, 2'b01);
  endtask

  task t_set_clear;
    do_reset;
    p_start;
    frame_done = 1'b1; rd_done_a = 1'b1; tick;
    frame_done = 1'b0; rd_done_a = 1'b0;
    chk("R6 set wins", full_flags, 2'b01);
    chk("R6 avail", frame_avail, 1);
  endtask

  initial begin
    t_reset;
    t_alternate;
    t_pref_full;
    t_skip;
    t_saturate;
    t_mode_off;
    t_busy;
    t_set_clear;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule